// File: doc/BRIEF.md
# LIN Error Flag Collector

This block watches a LIN bus controller for error conditions and keeps each one as a sticky flag in a 32-bit status word. Most flags are raised by one-cycle event strobes that the frame engine sends. These report a read-back bit mismatch, a bad checksum, an inconsistent synch field, a measured break delimiter, framing, overrun and noise. The block also detects two conditions itself. The first is a receive line held dominant for too long, counted in bit-time ticks. The second is a match between an 8-bit timeout counter and either of two 8-bit compare values.

Software reads the status word. It clears a flag by writing 1 to that flag's bit position, and writing 0 changes nothing. A compare match can also request that the controller return to idle, when that behaviour is enabled. The compare flag can additionally be cleared by hardware when the controller enters initialization mode. An aggregate interrupt output goes high while any enabled flag is set.

Top module: `lin_err_status`

## Requirements
- R1: After reset every bit of `statusWord` is 0. Flags use these bit positions (bit 0 is the LSB): stuck-low 15, compare 14, bit error 13, checksum 12, synch 11, delimiter 10, framing 9, overrun 8, noise 0. Every other bit always reads 0.
- R2: A cycle with `regWrEn`=1 clears each flag whose position in `regWrData` is 1. A flag whose position is 0 is left unchanged. If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R3: The stuck-low flag (bit 15) is set on the edge after the `bitTick` that makes the count of ticks with `rxLine`=0 reach STUCK_BITS+1 (101). Any cycle with `rxLine`=1 restarts the count from zero. The count saturates, so one dominant episode sets the flag only once.
- R4: The compare flag (bit 14) is set on the edge after any cycle in which `toCount` equals `cmpA` or `cmpB`.
- R5: `idleReq` is high for exactly one cycle, in the same cycle the compare flag changes from 0 to 1, provided `cfgIdleOnTo` was 1 in the cycle of the match.
- R6: With `cfgToMode`=1, the first cycle of `initMode`=1 after a cycle of `initMode`=0 clears the compare flag. With `cfgToMode`=0, entering initialization mode leaves the compare flag unchanged.
- R7: `bitMismatch` sets the bit-error flag (bit 13) when `inHeader`=0 (response phase). When `inHeader`=1 (header phase) it sets the flag only if `isMaster`=1.
- R8: `sumBad` sets the checksum flag (bit 12) only while both `sumDisA` and `sumDisB` are 0.
- R9: `syncBad` sets the synch flag (bit 11). `delimValid` sets the delimiter flag (bit 10) when `delimLen` is less than BIT_SAMPLES (16).
- R10: `frameErr`, `overrunErr` and `noiseErr` set bits 9, 8 and 0 respectively.
- R11: `errIrq` is 1 exactly when some flag is set whose enable bit is also 1. `irqEn` bits 0..8 enable, in order: stuck-low, compare, bit, checksum, synch, delimiter, framing, overrun, noise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxLine | input | 1 | Sampled receive line, 0 = dominant |
| bitTick | input | 1 | One pulse per bit time |
| bitMismatch | input | 1 | Strobe: transmitted and read-back bit differ |
| inHeader | input | 1 | 1 while a header is being sent, 0 during the response |
| isMaster | input | 1 | 1 when the node acts as master |
| sumBad | input | 1 | Strobe: received checksum differs from the computed one |
| sumDisA | input | 1 | Checksum-disable configuration bit A |
| sumDisB | input | 1 | Checksum-disable configuration bit B |
| syncBad | input | 1 | Strobe: inconsistent synch field |
| delimValid | input | 1 | Strobe: break delimiter measurement ready |
| delimLen | input | DELIM_W | Measured delimiter length in samples |
| frameErr | input | 1 | Strobe: framing error |
| overrunErr | input | 1 | Strobe: buffer overrun |
| noiseErr | input | 1 | Strobe: noise detected |
| toCount | input | CNT_W | Timeout counter value |
| cmpA | input | CNT_W | First compare value |
| cmpB | input | CNT_W | Second compare value |
| initMode | input | 1 | 1 while the controller is in initialization mode |
| cfgIdleOnTo | input | 1 | Enables the idle request on a compare match |
| cfgToMode | input | 1 | Enables hardware clear of the compare flag on init entry |
| irqEn | input | 9 | Per-flag interrupt enables |
| regWrEn | input | 1 | Status write strobe |
| regWrData | input | 32 | Write-1-to-clear data |
| statusWord | output | 32 | Status flags |
| errIrq | output | 1 | Aggregate error interrupt |
| idleReq | output | 1 | One-cycle request to return to idle |

## Verification
The hardest state to reach is the end of a dominant episode longer than a hundred bit times. The stimulus has to hold the line low through more than a hundred ticks. It first breaks one such run just short of the limit with a single recessive sample, to show the count restarts. It then clears the flag while the line is still low, to show it is not raised again. Equally narrow are the same-cycle collisions. The stimulus places a strobe, the matching clear write and an initialization-mode entry on a single edge, and a behavioural model judges the result on every clock.

// File: rtl/lin_err_pkg.sv
package lin_err_pkg;
  localparam int NUM_FLAGS = 9;
  localparam int WORD_W    = 32;

  localparam int F_STUCK = 0;
  localparam int F_CMP   = 1;
  localparam int F_BIT   = 2;
  localparam int F_SUM   = 3;
  localparam int F_SYNC  = 4;
  localparam int F_DELIM = 5;
  localparam int F_FRAME = 6;
  localparam int F_OVR   = 7;
  localparam int F_NOISE = 8;

  // position of flag index in the status word (LSB = 0)
  function automatic int flagPos(input int idx);
    return (idx < 8) ? (15 - idx) : 0;
  endfunction

  typedef struct packed {
    logic [NUM_FLAGS-1:0] set;
    logic                 cmpHwClr;
    logic                 idleHit;
  } evtT;
endpackage

// File: rtl/lin_err_ctrl.sv
module lin_err_ctrl
  import lin_err_pkg::*;
#(
  parameter int STUCK_BITS  = 100,
  parameter int CNT_W       = 8,
  parameter int DELIM_W     = 5,
  parameter int BIT_SAMPLES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxLine,
  input  logic               bitTick,
  input  logic               bitMismatch,
  input  logic               inHeader,
  input  logic               isMaster,
  input  logic               sumBad,
  input  logic               sumDisA,
  input  logic               sumDisB,
  input  logic               syncBad,
  input  logic               delimValid,
  input  logic [DELIM_W-1:0] delimLen,
  input  logic               frameErr,
  input  logic               overrunErr,
  input  logic               noiseErr,
  input  logic [CNT_W-1:0]   toCount,
  input  logic [CNT_W-1:0]   cmpA,
  input  logic [CNT_W-1:0]   cmpB,
  input  logic               initMode,
  input  logic               cfgIdleOnTo,
  input  logic               cfgToMode,
  output evtT                evt
);
  localparam int LOW_LIMIT = STUCK_BITS + 1;
  localparam int LOW_W     = $clog2(LOW_LIMIT + 1);

  logic [LOW_W-1:0] lowCnt;
  logic             initPrev;
  logic             cmpHit;
  logic             lowAtEdge;

  assign lowAtEdge = (lowCnt == LOW_W'(LOW_LIMIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (rxLine) begin
      lowCnt <= '0;
    end else if (bitTick && (lowCnt != LOW_W'(LOW_LIMIT))) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initPrev <= 1'b0;
    else       initPrev <= initMode;
  end

  assign cmpHit = (toCount == cmpA) || (toCount == cmpB);

  always_comb begin
    evt = '0;
    evt.set[F_STUCK] = !rxLine && bitTick && lowAtEdge;
    evt.set[F_CMP]   = cmpHit;
    evt.set[F_BIT]   = bitMismatch && (!inHeader || isMaster);
    evt.set[F_SUM]   = sumBad && !sumDisA && !sumDisB;
    evt.set[F_SYNC]  = syncBad;
    evt.set[F_DELIM] = delimValid && (delimLen < DELIM_W'(BIT_SAMPLES));
    evt.set[F_FRAME] = frameErr;
    evt.set[F_OVR]   = overrunErr;
    evt.set[F_NOISE] = noiseErr;
    evt.cmpHwClr     = cfgToMode && initMode && !initPrev;
    evt.idleHit      = cfgIdleOnTo && cmpHit;
  end

  // R3
  lowcnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= LOW_W'(LOW_LIMIT));
  // R3
  lowcnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxLine |=> (lowCnt == '0));
  // R7
  hdr_slave_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitMismatch && inHeader && !isMaster) |-> !evt.set[F_BIT]);
endmodule

// File: rtl/lin_err_dp.sv
module lin_err_dp
  import lin_err_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  evtT                  evt,
  input  logic [NUM_FLAGS-1:0] irqEn,
  input  logic                 regWrEn,
  input  logic [WORD_W-1:0]    regWrData,
  output logic [WORD_W-1:0]    statusWord,
  output logic                 errIrq,
  output logic                 idleReq
);
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] swClr;
  logic                 unusedWr;

  assign unusedWr = ^regWrData;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    localparam int POS = flagPos(i);
    logic hwClr;
    assign swClr[i] = regWrEn && regWrData[POS];
    if (i == F_CMP) begin : g_hw
      assign hwClr = evt.cmpHwClr;
    end else begin : g_nohw
      assign hwClr = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           flags[i] <= 1'b0;
      else if (evt.set[i]) flags[i] <= 1'b1;
      else if (swClr[i] || hwClr) flags[i] <= 1'b0;
    end

    // R2
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      evt.set[i] |=> statusWord[POS]);
    // R2
    zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
      (statusWord[POS] && !(regWrEn && regWrData[POS]) && !hwClr) |=> statusWord[POS]);
    // R2
    one_write_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regWrData[POS] && !evt.set[i]) |=> !statusWord[POS]);
  end

  always_comb begin
    statusWord = '0;
    for (int k = 0; k < NUM_FLAGS; k++) statusWord[flagPos(k)] = flags[k];
  end

  assign errIrq = |(flags & irqEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idleReq <= 1'b0;
    else       idleReq <= evt.idleHit && !flags[F_CMP];
  end

  // R5
  idle_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleReq |=> !idleReq);
endmodule

// File: rtl/lin_err_status.sv
module lin_err_status
  import lin_err_pkg::*;
#(
  parameter int STUCK_BITS  = 100,
  parameter int CNT_W       = 8,
  parameter int DELIM_W     = 5,
  parameter int BIT_SAMPLES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxLine,
  input  logic               bitTick,
  input  logic               bitMismatch,
  input  logic               inHeader,
  input  logic               isMaster,
  input  logic               sumBad,
  input  logic               sumDisA,
  input  logic               sumDisB,
  input  logic               syncBad,
  input  logic               delimValid,
  input  logic [DELIM_W-1:0] delimLen,
  input  logic               frameErr,
  input  logic               overrunErr,
  input  logic               noiseErr,
  input  logic [CNT_W-1:0]   toCount,
  input  logic [CNT_W-1:0]   cmpA,
  input  logic [CNT_W-1:0]   cmpB,
  input  logic               initMode,
  input  logic               cfgIdleOnTo,
  input  logic               cfgToMode,
  input  logic [8:0]         irqEn,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  output logic [31:0]        statusWord,
  output logic               errIrq,
  output logic               idleReq
);
  evtT evt;

  lin_err_ctrl #(
    .STUCK_BITS(STUCK_BITS), .CNT_W(CNT_W),
    .DELIM_W(DELIM_W), .BIT_SAMPLES(BIT_SAMPLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .bitTick(bitTick),
    .bitMismatch(bitMismatch), .inHeader(inHeader), .isMaster(isMaster),
    .sumBad(sumBad), .sumDisA(sumDisA), .sumDisB(sumDisB),
    .syncBad(syncBad), .delimValid(delimValid), .delimLen(delimLen),
    .frameErr(frameErr), .overrunErr(overrunErr), .noiseErr(noiseErr),
    .toCount(toCount), .cmpA(cmpA), .cmpB(cmpB), .initMode(initMode),
    .cfgIdleOnTo(cfgIdleOnTo), .cfgToMode(cfgToMode), .evt(evt)
  );

  lin_err_dp i_dp (
    .clk(clk), .rstN(rstN), .evt(evt), .irqEn(irqEn),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .statusWord(statusWord), .errIrq(errIrq), .idleReq(idleReq)
  );

  // R8
  sum_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sumDisA || sumDisB) && !statusWord[12]) |=> !statusWord[12]);
  // R5
  idle_has_cmp_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleReq |-> statusWord[14]);
  // R1
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & 32'h7FFF_00FE) == 32'h0);
endmodule

// File: tb/test_lin_err_status.sv
module test_lin_err_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1, bitTick = 1'b0, bitMismatch = 1'b0, inHeader = 1'b0, isMaster = 1'b0;
  logic sumBad = 1'b0, sumDisA = 1'b0, sumDisB = 1'b0, syncBad = 1'b0, delimValid = 1'b0;
  logic [4:0] delimLen = 5'd0;
  logic frameErr = 1'b0, overrunErr = 1'b0, noiseErr = 1'b0;
  logic [7:0] toCount = 8'd0, cmpA = 8'hF0, cmpB = 8'hF1;
  logic initMode = 1'b0, cfgIdleOnTo = 1'b0, cfgToMode = 1'b0;
  logic [8:0] irqEn = 9'h1FF;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] statusWord;
  logic errIrq, idleReq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  string phase = "R1 reset";

  always #4 clk = ~clk;

  lin_err_status i_lin_err_status (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .bitTick(bitTick),
    .bitMismatch(bitMismatch), .inHeader(inHeader), .isMaster(isMaster),
    .sumBad(sumBad), .sumDisA(sumDisA), .sumDisB(sumDisB),
    .syncBad(syncBad), .delimValid(delimValid), .delimLen(delimLen),
    .frameErr(frameErr), .overrunErr(overrunErr), .noiseErr(noiseErr),
    .toCount(toCount), .cmpA(cmpA), .cmpB(cmpB), .initMode(initMode),
    .cfgIdleOnTo(cfgIdleOnTo), .cfgToMode(cfgToMode), .irqEn(irqEn),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .statusWord(statusWord), .errIrq(errIrq), .idleReq(idleReq)
  );

  // reference model
  int posOf[9] = '{15, 14, 13, 12, 11, 10, 9, 8, 0};
  string tagOf[9] = '{"R3", "R4", "R7", "R8", "R9", "R9", "R10", "R10", "R10"};
  bit mFlag[9];
  bit mSet[9];
  bit mIdle;
  bit mInitPrev;
  int lowRun;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (mFlag[k]) mFlag[k] = 1'b0;
      mIdle = 1'b0; mInitPrev = 1'b0; lowRun = 0;
    end else begin
      bit hit, hwClr;
      hit = (toCount == cmpA) || (toCount == cmpB);
      hwClr = cfgToMode && initMode && !mInitPrev;
      mSet[0] = !rxLine && bitTick && (lowRun == 100);
      mSet[1] = hit;
      mSet[2] = bitMismatch && (!inHeader || isMaster);
      mSet[3] = sumBad && !sumDisA && !sumDisB;
      mSet[4] = syncBad;
      mSet[5] = delimValid && (delimLen < 16);
      mSet[6] = frameErr;
      mSet[7] = overrunErr;
      mSet[8] = noiseErr;
      mIdle = cfgIdleOnTo && hit && !mFlag[1];
      for (int k = 0; k < 9; k++) begin
        bit clr;
        clr = (regWrEn && regWrData[posOf[k]]) || (k == 1 && hwClr);
        if (mSet[k]) mFlag[k] = 1'b1;
        else if (clr) mFlag[k] = 1'b0;
      end
      if (rxLine) lowRun = 0;
      else if (bitTick && lowRun <= 100) lowRun = lowRun + 1;
      mInitPrev = initMode;
    end
  end

  task automatic compareAll();
    logic [31:0] expWord;
    bit expIrq;
    expWord = 32'h0;
    expIrq = 1'b0;
    for (int k = 0; k < 9; k++) begin
      expWord[posOf[k]] = mFlag[k];
      if (mFlag[k] && irqEn[k]) expIrq = 1'b1;
    end
    testsRun++;
    if (statusWord !== expWord) begin
      testsFailed++;
      for (int b = 0; b < 32; b++) begin
        if (statusWord[b] !== expWord[b]) begin
          string t;
          t = "R1";
          for (int k = 0; k < 9; k++) if (posOf[k] == b) t = tagOf[k];
          $display("FAIL %s [%s] statusWord bit %0d actual %0b expected %0b (word %h vs %h)",
                   t, phase, b, statusWord[b], expWord[b], statusWord, expWord);
        end
      end
    end
    testsRun++;
    if (errIrq !== expIrq) begin
      testsFailed++;
      $display("FAIL R11 [%s] errIrq actual %0b expected %0b", phase, errIrq, expIrq);
    end
    testsRun++;
    if (idleReq !== mIdle) begin
      testsFailed++;
      $display("FAIL R5 [%s] idleReq actual %0b expected %0b", phase, idleReq, mIdle);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
    bitMismatch = 1'b0; sumBad = 1'b0; syncBad = 1'b0; delimValid = 1'b0;
    frameErr = 1'b0; overrunErr = 1'b0; noiseErr = 1'b0; regWrEn = 1'b0; regWrData = 32'h0;
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic clearAll();
    regWrEn = 1'b1; regWrData = 32'hFFFF_FFFF; step();
  endtask

  initial begin
    steps(3);
    rstN = 1'b1;
    steps(3);

    phase = "R10 strobes";
    frameErr = 1'b1; step();
    overrunErr = 1'b1; step();
    noiseErr = 1'b1; step();
    phase = "R9 synch and delimiter";
    syncBad = 1'b1; step();
    delimValid = 1'b1; delimLen = 5'd20; step();
    delimValid = 1'b1; delimLen = 5'd16; step();
    steps(1);
    delimValid = 1'b1; delimLen = 5'd15; step();
    steps(1);

    phase = "R2 write zero";
    regWrEn = 1'b1; regWrData = 32'h0; step();
    regWrEn = 1'b1; regWrData = 32'h7FFF_00FE; step();
    phase = "R2 selective clear";
    regWrEn = 1'b1; regWrData = 32'h0000_0201; step();
    steps(1);
    phase = "R2 set wins";
    frameErr = 1'b1; regWrEn = 1'b1; regWrData = 32'h0000_0200; step();
    steps(1);
    clearAll();

    phase = "R7 bit error qualification";
    bitMismatch = 1'b1; inHeader = 1'b1; isMaster = 1'b0; step();
    steps(1);
    bitMismatch = 1'b1; inHeader = 1'b1; isMaster = 1'b1; step();
    clearAll();
    bitMismatch = 1'b1; inHeader = 1'b0; isMaster = 1'b0; step();
    clearAll();

    phase = "R8 checksum disable";
    sumBad = 1'b1; sumDisA = 1'b1; step();
    sumDisA = 1'b0; sumBad = 1'b1; sumDisB = 1'b1; step();
    sumDisB = 1'b0; steps(1);
    sumBad = 1'b1; step();
    clearAll();

    phase = "R3 stuck low restart";
    rxLine = 1'b0; bitTick = 1'b1;
    steps(100);
    rxLine = 1'b1; step();
    rxLine = 1'b0; steps(100);
    phase = "R3 stuck low set";
    steps(3);
    phase = "R3 once per episode";
    clearAll();
    steps(20);
    bitTick = 1'b0; rxLine = 1'b1; steps(2);
    rxLine = 1'b0;
    for (int k = 0; k < 210; k++) begin bitTick = k[0]; step(); end
    rxLine = 1'b1; bitTick = 1'b0;
    clearAll();

    phase = "R4 R5 compare A with idle";
    cfgIdleOnTo = 1'b1;
    toCount = 8'd10; cmpA = 8'd12; steps(2);
    toCount = 8'd12; step();
    toCount = 8'd13; steps(2);
    phase = "R4 compare B";
    clearAll();
    cfgIdleOnTo = 1'b0; cmpB = 8'd40; toCount = 8'd40; step();
    toCount = 8'd41; steps(2);

    phase = "R6 keep in init";
    cfgToMode = 1'b0; initMode = 1'b1; steps(2);
    initMode = 1'b0; steps(1);
    phase = "R6 clear in init";
    cfgToMode = 1'b1; initMode = 1'b1; steps(3);
    initMode = 1'b0; steps(1);
    phase = "R6 set and init entry";
    toCount = 8'd40; initMode = 1'b1; cfgIdleOnTo = 1'b1; step();
    toCount = 8'd41; steps(2);
    initMode = 1'b0; cfgToMode = 1'b0; cfgIdleOnTo = 1'b0; clearAll();

    phase = "R11 interrupt enables";
    noiseErr = 1'b1; frameErr = 1'b1; step();
    irqEn = 9'h0BF; steps(2);
    irqEn = 9'h03F; steps(2);
    irqEn = 9'h100; steps(2);
    irqEn = 9'h1FF; clearAll();
    steps(2);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired in phase %s actual running expected done", phase);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule